// File: doc/BRIEF.md
# DDR SDRAM Power-Up Initialization Sequencer

This block brings a DDR SDRAM device from power-on to a state where it accepts normal commands. After reset it holds clock-enable low for a long stable-clock interval. It then raises clock-enable with a NOP and issues a fixed series of commands: precharge-all, an extended mode register write that turns the DLL on, a DLL-reset mode register write, a second precharge-all, a programmable number of auto-refresh commands, and a final mode register write that sets the operating mode. Every gap between commands is a parameterized cycle count, and NOP fills every cycle between commands.

A parameter selects how the DLL-reset step is placed. It can come before the second precharge-all, come after it, or be left out. When it is left out, the DLL lock interval is timed from the extended mode write. The done flag rises only when the final mode write spacing and the DLL lock interval have both run out. It then stays high, with NOP on the command pins, until the next reset. The mode and extended-mode values come in as inputs. The sequencer forces the address bits that control the DLL.

Top module: `ddr_init_seq`

## Requirements
- R1: After reset release, `cke` stays low for exactly STABLE_CYCLES sampled cycles, then goes high and stays high until the next reset. No command other than NOP is ever driven while `cke` is low.
- R2: The command pins {csN,rasN,casN,weN} read NOP (0,1,1,1) in reset, during the stable wait, in the first cycle with `cke` high, and in every cycle that carries no sequence command.
- R3: The command order depends on DLL_ORDER. The fixed part is precharge-all, then extended mode write. DLL_ORDER=0 continues with DLL-reset write, then precharge-all. DLL_ORDER=1 continues with precharge-all, then DLL-reset write. DLL_ORDER=2 continues with precharge-all only. All three then finish with REFRESH_COUNT auto-refreshes and the final mode write.
- R4: Precharge-all is encoded 0,0,1,0 with addr bit 10 high, all other address bits low and ba=0. Auto-refresh is encoded 0,0,0,1 with ba=0 and addr=0. Both mode writes are encoded 0,0,0,0.
- R5: The extended mode write drives ba=2'b01 and addr = extModeReg with bit 0 forced low.
- R6: The DLL-reset mode write drives ba=2'b00 and addr = modeReg with bit 8 forced high.
- R7: The final mode write drives ba=2'b00 and addr = modeReg with bit 8 forced low.
- R8: The first precharge-all comes one cycle after `cke` rises. The next command comes exactly TRP_CYCLES after a precharge-all, TRFC_CYCLES after an auto-refresh, and TMRD_CYCLES after a mode write.
- R9: Exactly REFRESH_COUNT auto-refresh commands are issued (REFRESH_COUNT >= 2).
- R10: `initDone` rises in the cycle max(final mode write + TMRD_CYCLES, lock start + LOCK_CYCLES). The lock start is the DLL-reset write, or the extended mode write when DLL_ORDER=2. `initDone` then stays high with NOP on the command pins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| modeReg | input | ADDR_W | Operating mode value for the mode writes |
| extModeReg | input | ADDR_W | Extended mode value for the DLL-enable write |
| cke | output | 1 | Clock enable to the device |
| csN | output | 1 | Chip select, active low |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus |
| initDone | output | 1 | Sequence complete, sticky until reset |

## Verification
The bench runs four small configurations: all three DLL step placements, plus one where the lock interval ends in the same cycle as the final spacing. Each run is compared cycle by cycle against a schedule the bench computes from the gap parameters. Giving `initDone` the later of the two deadlines is checked in three cases: lock dominates, timing dominates, and a tie. A design that tested only one deadline, or that was off by one cycle on either, raises the flag a cycle early or late.

Non-zero mode inputs are used with bit 8 set and with bit 0 set. A design that passed those bits through unforced would repeat the DLL reset in the final write, or would disable the DLL in the extended write. Running three auto-refreshes catches a counter that is hard-wired to two.

// File: rtl/ddr_init_pkg.sv
package ddr_init_pkg;

  typedef enum logic [2:0] {
    CMD_NOP,
    CMD_PRE_ALL,
    CMD_EXT_DLL_ON,
    CMD_MODE_DLL_RST,
    CMD_AUTO_REF,
    CMD_MODE_RUN
  } seqCmd_t;

  typedef enum logic [1:0] {
    GAP_TRP,
    GAP_TRFC,
    GAP_TMRD
  } gapSel_t;

  typedef struct packed {
    seqCmd_t cmd;
    logic    ckeOn;
    logic    gapLoad;
    gapSel_t gapSel;
    logic    lockStart;
    logic    finish;
  } seqStrobe_t;

  typedef enum logic [3:0] {
    ST_STABLE,
    ST_CKE_ON,
    ST_PRE1,
    ST_EXT_DLL,
    ST_DLL_RST,
    ST_PRE2,
    ST_REFRESH,
    ST_MODE_RUN,
    ST_GAP,
    ST_DONE
  } seqState_t;

  localparam logic [3:0] PINS_NOP  = 4'b0111;
  localparam logic [3:0] PINS_PRE  = 4'b0010;
  localparam logic [3:0] PINS_REF  = 4'b0001;
  localparam logic [3:0] PINS_MODE = 4'b0000;

endpackage

// File: rtl/ddr_init_ctrl.sv
module ddr_init_ctrl
  import ddr_init_pkg::*;
#(
  parameter int REFRESH_COUNT = 2,
  parameter int DLL_ORDER     = 0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       gapZero,
  input  logic       lockOk,
  output seqStrobe_t strobe
);

  localparam int REF_W = $clog2(REFRESH_COUNT + 1);

  seqState_t        state, stNext, resume, resumeNext;
  logic [REF_W-1:0] refLeft;

  // Order-dependent successors of the DLL-related steps
  localparam seqState_t AFTER_EXT = (DLL_ORDER == 0) ? ST_DLL_RST : ST_PRE2;
  localparam seqState_t AFTER_RST = (DLL_ORDER == 0) ? ST_PRE2 : ST_REFRESH;
  localparam seqState_t AFTER_PRE = (DLL_ORDER == 1) ? ST_DLL_RST : ST_REFRESH;

  always_comb begin
    strobe     = '0;
    stNext     = state;
    resumeNext = resume;
    unique case (state)
      ST_STABLE: if (gapZero) stNext = ST_CKE_ON;
      ST_CKE_ON: begin
        strobe.ckeOn = 1'b1;
        stNext       = ST_PRE1;
      end
      ST_PRE1: begin
        strobe.cmd     = CMD_PRE_ALL;
        strobe.gapLoad = 1'b1;
        strobe.gapSel  = GAP_TRP;
        stNext         = ST_GAP;
        resumeNext     = ST_EXT_DLL;
      end
      ST_EXT_DLL: begin
        strobe.cmd       = CMD_EXT_DLL_ON;
        strobe.gapLoad   = 1'b1;
        strobe.gapSel    = GAP_TMRD;
        strobe.lockStart = (DLL_ORDER == 2);
        stNext           = ST_GAP;
        resumeNext       = AFTER_EXT;
      end
      ST_DLL_RST: begin
        strobe.cmd       = CMD_MODE_DLL_RST;
        strobe.gapLoad   = 1'b1;
        strobe.gapSel    = GAP_TMRD;
        strobe.lockStart = 1'b1;
        stNext           = ST_GAP;
        resumeNext       = AFTER_RST;
      end
      ST_PRE2: begin
        strobe.cmd     = CMD_PRE_ALL;
        strobe.gapLoad = 1'b1;
        strobe.gapSel  = GAP_TRP;
        stNext         = ST_GAP;
        resumeNext     = AFTER_PRE;
      end
      ST_REFRESH: begin
        strobe.cmd     = CMD_AUTO_REF;
        strobe.gapLoad = 1'b1;
        strobe.gapSel  = GAP_TRFC;
        stNext         = ST_GAP;
        resumeNext     = (refLeft == REF_W'(1)) ? ST_MODE_RUN : ST_REFRESH;
      end
      ST_MODE_RUN: begin
        strobe.cmd     = CMD_MODE_RUN;
        strobe.gapLoad = 1'b1;
        strobe.gapSel  = GAP_TMRD;
        stNext         = ST_GAP;
        resumeNext     = ST_DONE;
      end
      ST_GAP: if (gapZero && (resume != ST_DONE || lockOk)) stNext = resume;
      ST_DONE: strobe.finish = 1'b1;
      default: stNext = ST_STABLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_STABLE;
      resume  <= ST_STABLE;
      refLeft <= REF_W'(REFRESH_COUNT);
    end else begin
      state  <= stNext;
      resume <= resumeNext;
      if (state == ST_REFRESH) refLeft <= refLeft - REF_W'(1);
    end
  end

  assert_ref_budget_R9: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_REFRESH) |-> (refLeft != '0));

  assert_done_after_lock_R10: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_DONE) |-> lockOk);

endmodule

// File: rtl/ddr_init_dp.sv
module ddr_init_dp
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int BA_W          = 2,
  parameter int STABLE_CYCLES = 20000,
  parameter int TRP_CYCLES    = 3,
  parameter int TRFC_CYCLES   = 10,
  parameter int TMRD_CYCLES   = 2,
  parameter int LOCK_CYCLES   = 200
) (
  input  logic              clk,
  input  logic              rstN,
  input  seqStrobe_t        strobe,
  input  logic [ADDR_W-1:0] modeReg,
  input  logic [ADDR_W-1:0] extModeReg,
  output logic              gapZero,
  output logic              lockOk,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  localparam int M1      = (TRP_CYCLES > TRFC_CYCLES) ? TRP_CYCLES : TRFC_CYCLES;
  localparam int M2      = (M1 > TMRD_CYCLES) ? M1 : TMRD_CYCLES;
  localparam int GAP_MAX = (M2 > STABLE_CYCLES) ? M2 : STABLE_CYCLES;
  localparam int GAP_W   = $clog2(GAP_MAX + 1);
  localparam int LOCK_W  = $clog2(LOCK_CYCLES + 1);
  localparam int A_ALL   = 10;
  localparam int A_DLLRST = 8;
  localparam int A_DLLOFF = 0;

  logic [GAP_W-1:0]  gapCnt, gapInit;
  logic [LOCK_W-1:0] lockCnt;
  logic              lockArmed;
  logic [3:0]        pinsNext, pinsQ;
  logic [BA_W-1:0]   baNext;
  logic [ADDR_W-1:0] addrNext;

  // Spacing counter: loaded with gap-2 so the next command lands gap cycles later
  always_comb begin
    unique case (strobe.gapSel)
      GAP_TRP:  gapInit = GAP_W'(TRP_CYCLES - 2);
      GAP_TRFC: gapInit = GAP_W'(TRFC_CYCLES - 2);
      default:  gapInit = GAP_W'(TMRD_CYCLES - 2);
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                gapCnt <= GAP_W'(STABLE_CYCLES - 1);
    else if (strobe.gapLoad)  gapCnt <= gapInit;
    else if (gapCnt != '0)    gapCnt <= gapCnt - GAP_W'(1);
  end
  assign gapZero = (gapCnt == '0);

  // DLL lock interval
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lockCnt   <= '0;
      lockArmed <= 1'b0;
    end else if (strobe.lockStart) begin
      lockCnt   <= LOCK_W'(LOCK_CYCLES - 2);
      lockArmed <= 1'b1;
    end else if (lockCnt != '0) begin
      lockCnt <= lockCnt - LOCK_W'(1);
    end
  end
  assign lockOk = lockArmed && (lockCnt == '0);

  // Command decode
  always_comb begin
    pinsNext = PINS_NOP;
    baNext   = '0;
    addrNext = '0;
    unique case (strobe.cmd)
      CMD_PRE_ALL: begin
        pinsNext        = PINS_PRE;
        addrNext[A_ALL] = 1'b1;
      end
      CMD_EXT_DLL_ON: begin
        pinsNext           = PINS_MODE;
        baNext             = BA_W'(1);
        addrNext           = extModeReg;
        addrNext[A_DLLOFF] = 1'b0;
      end
      CMD_MODE_DLL_RST: begin
        pinsNext           = PINS_MODE;
        addrNext           = modeReg;
        addrNext[A_DLLRST] = 1'b1;
      end
      CMD_AUTO_REF: pinsNext = PINS_REF;
      CMD_MODE_RUN: begin
        pinsNext           = PINS_MODE;
        addrNext           = modeReg;
        addrNext[A_DLLRST] = 1'b0;
      end
      default: pinsNext = PINS_NOP;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cke      <= 1'b0;
      pinsQ    <= PINS_NOP;
      ba       <= '0;
      addr     <= '0;
      initDone <= 1'b0;
    end else begin
      if (strobe.ckeOn)  cke      <= 1'b1;
      if (strobe.finish) initDone <= 1'b1;
      pinsQ <= pinsNext;
      ba    <= baNext;
      addr  <= addrNext;
    end
  end
  assign {csN, rasN, casN, weN} = pinsQ;

  assert_cke_holds_R1: assert property (@(posedge clk) disable iff (!rstN)
    cke |=> cke);

  assert_cmd_needs_cke_R1: assert property (@(posedge clk) disable iff (!rstN)
    ({csN, rasN, casN, weN} != PINS_NOP) |-> cke);

  assert_nop_on_cke_rise_R2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(cke) |-> ({csN, rasN, casN, weN} == PINS_NOP));

  assert_cmd_isolated_R8: assert property (@(posedge clk) disable iff (!rstN)
    ({csN, rasN, casN, weN} != PINS_NOP) |=> ({csN, rasN, casN, weN} == PINS_NOP));

  assert_done_sticky_R10: assert property (@(posedge clk) disable iff (!rstN)
    initDone |=> initDone);

  assert_quiet_after_done_R10: assert property (@(posedge clk) disable iff (!rstN)
    initDone |-> ({csN, rasN, casN, weN} == PINS_NOP));

endmodule

// File: rtl/ddr_init_seq.sv
module ddr_init_seq
  import ddr_init_pkg::*;
#(
  parameter int ADDR_W        = 11,
  parameter int BA_W          = 2,
  parameter int STABLE_CYCLES = 20000,
  parameter int TRP_CYCLES    = 3,
  parameter int TRFC_CYCLES   = 10,
  parameter int TMRD_CYCLES   = 2,
  parameter int LOCK_CYCLES   = 200,
  parameter int REFRESH_COUNT = 2,
  parameter int DLL_ORDER     = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] modeReg,
  input  logic [ADDR_W-1:0] extModeReg,
  output logic              cke,
  output logic              csN,
  output logic              rasN,
  output logic              casN,
  output logic              weN,
  output logic [BA_W-1:0]   ba,
  output logic [ADDR_W-1:0] addr,
  output logic              initDone
);

  seqStrobe_t strobe;
  logic       gapZero;
  logic       lockOk;

  ddr_init_ctrl #(
    .REFRESH_COUNT(REFRESH_COUNT),
    .DLL_ORDER    (DLL_ORDER)
  ) ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .gapZero(gapZero),
    .lockOk (lockOk),
    .strobe (strobe)
  );

  ddr_init_dp #(
    .ADDR_W       (ADDR_W),
    .BA_W         (BA_W),
    .STABLE_CYCLES(STABLE_CYCLES),
    .TRP_CYCLES   (TRP_CYCLES),
    .TRFC_CYCLES  (TRFC_CYCLES),
    .TMRD_CYCLES  (TMRD_CYCLES),
    .LOCK_CYCLES  (LOCK_CYCLES)
  ) dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .modeReg   (modeReg),
    .extModeReg(extModeReg),
    .gapZero   (gapZero),
    .lockOk    (lockOk),
    .cke       (cke),
    .csN       (csN),
    .rasN      (rasN),
    .casN      (casN),
    .weN       (weN),
    .ba        (ba),
    .addr      (addr),
    .initDone  (initDone)
  );

endmodule

// File: tb/ddr_init_seq_test.sv
module ddr_init_seq_probe #(
  parameter int         S     = 5,
  parameter int         TRP   = 3,
  parameter int         TRFC  = 6,
  parameter int         TMRD  = 2,
  parameter int         LOCK  = 20,
  parameter int         NREF  = 2,
  parameter int         ORDER = 0,
  parameter logic [10:0] MODE = 11'h000,
  parameter logic [10:0] EXT  = 11'h000
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cke,
  input  logic        csN,
  input  logic        rasN,
  input  logic        casN,
  input  logic        weN,
  input  logic [1:0]  ba,
  input  logic [10:0] addr,
  input  logic        initDone,
  output int          checks,
  output int          errors,
  output logic        finished
);

  int          idx = 0;
  int          nEv = 0;
  int          evT[16];
  logic [3:0]  evPins[16];
  logic [1:0]  evBa[16];
  logic [10:0] evAddr[16];
  string       evTag[16];
  int          doneT;
  int          lockT;
  int          refSeen = 0;
  bit          resetChecked = 0;

  task automatic addEv(int t, logic [3:0] p, logic [1:0] b, logic [10:0] a, string tag);
    evT[nEv] = t; evPins[nEv] = p; evBa[nEv] = b; evAddr[nEv] = a; evTag[nEv] = tag;
    nEv++;
  endtask

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s cycle %0d: actual %0h expected %0h", req, what, idx, act, exp);
    end
  endtask

  initial begin
    int t;
    checks = 0; errors = 0; finished = 0;
    t = S + 2;                                              // R8: one cycle after cke rise
    addEv(t, 4'b0010, 2'b00, 11'h400, "R4"); t += TRP;
    addEv(t, 4'b0000, 2'b01, EXT & ~11'h001, "R5"); lockT = t; t += TMRD;
    if (ORDER == 0) begin
      addEv(t, 4'b0000, 2'b00, MODE | 11'h100, "R6"); lockT = t; t += TMRD;
      addEv(t, 4'b0010, 2'b00, 11'h400, "R4"); t += TRP;
    end else if (ORDER == 1) begin
      addEv(t, 4'b0010, 2'b00, 11'h400, "R4"); t += TRP;
      addEv(t, 4'b0000, 2'b00, MODE | 11'h100, "R6"); lockT = t; t += TMRD;
    end else begin
      addEv(t, 4'b0010, 2'b00, 11'h400, "R4"); t += TRP;
    end
    for (int r = 0; r < NREF; r++) begin
      addEv(t, 4'b0001, 2'b00, 11'h000, "R4"); t += TRFC;
    end
    addEv(t, 4'b0000, 2'b00, MODE & ~11'h100, "R7"); t += TMRD;
    doneT = (t > lockT + LOCK) ? t : lockT + LOCK;
  end

  always @(posedge clk) if (rstN) idx <= idx + 1;

  always @(negedge clk) begin
    logic [3:0] pins;
    int         hit;
    pins = {csN, rasN, casN, weN};
    if (!rstN) begin
      if (!resetChecked) begin
        resetChecked = 1;
        chk(cke == 1'b0, "R1", "cke in reset", cke, 0);
        chk(pins == 4'b0111, "R2", "pins in reset", pins, 4'b0111);
        chk(initDone == 1'b0, "R10", "initDone in reset", initDone, 0);
      end
    end else if (idx > 0 && !finished) begin
      chk(cke == (idx > S), "R1", "cke", cke, (idx > S));
      hit = -1;
      for (int e = 0; e < nEv; e++) if (evT[e] == idx) hit = e;
      if (hit < 0) begin
        chk(pins == 4'b0111, "R2 R8", "idle pins", pins, 4'b0111);
      end else begin
        chk(pins == evPins[hit], "R3 R8", "command pins", pins, evPins[hit]);
        chk(ba == evBa[hit], evTag[hit], "bank", ba, evBa[hit]);
        chk(addr == evAddr[hit], evTag[hit], "address", addr, evAddr[hit]);
      end
      if (pins == 4'b0001) refSeen++;
      chk(initDone == (idx >= doneT), "R10", "initDone", initDone, (idx >= doneT));
      if (idx == doneT) chk(refSeen == NREF, "R9", "refresh count", refSeen, NREF);
      if (idx >= doneT + 8) finished = 1;
    end
  end

endmodule

module ddr_init_seq_test;

  logic clk = 0;
  logic rstN = 0;
  always #10 clk = ~clk;   // 50 MHz

  localparam logic [10:0] MODE_A = 11'h032;
  localparam logic [10:0] MODE_B = 11'h132;
  localparam logic [10:0] EXT_B  = 11'h003;

  logic        cke[4], csN[4], rasN[4], casN[4], weN[4], initDone[4];
  logic [1:0]  ba[4];
  logic [10:0] addr[4];
  int          chkN[4], errN[4];
  logic        fin[4];

  // Lock dominates by one cycle
  ddr_init_seq #(.STABLE_CYCLES(5), .TRP_CYCLES(3), .TRFC_CYCLES(6), .TMRD_CYCLES(2),
    .LOCK_CYCLES(20), .REFRESH_COUNT(2), .DLL_ORDER(0)) uut (
    .clk(clk), .rstN(rstN), .modeReg(MODE_A), .extModeReg(11'h000),
    .cke(cke[0]), .csN(csN[0]), .rasN(rasN[0]), .casN(casN[0]), .weN(weN[0]),
    .ba(ba[0]), .addr(addr[0]), .initDone(initDone[0]));
  ddr_init_seq_probe #(.S(5), .TRP(3), .TRFC(6), .TMRD(2), .LOCK(20), .NREF(2),
    .ORDER(0), .MODE(MODE_A), .EXT(11'h000)) probeA (
    .clk(clk), .rstN(rstN), .cke(cke[0]), .csN(csN[0]), .rasN(rasN[0]), .casN(casN[0]),
    .weN(weN[0]), .ba(ba[0]), .addr(addr[0]), .initDone(initDone[0]),
    .checks(chkN[0]), .errors(errN[0]), .finished(fin[0]));

  // Swapped order, three refreshes, timing dominates, forced bits exercised
  ddr_init_seq #(.STABLE_CYCLES(4), .TRP_CYCLES(2), .TRFC_CYCLES(5), .TMRD_CYCLES(3),
    .LOCK_CYCLES(8), .REFRESH_COUNT(3), .DLL_ORDER(1)) uutSwap (
    .clk(clk), .rstN(rstN), .modeReg(MODE_B), .extModeReg(EXT_B),
    .cke(cke[1]), .csN(csN[1]), .rasN(rasN[1]), .casN(casN[1]), .weN(weN[1]),
    .ba(ba[1]), .addr(addr[1]), .initDone(initDone[1]));
  ddr_init_seq_probe #(.S(4), .TRP(2), .TRFC(5), .TMRD(3), .LOCK(8), .NREF(3),
    .ORDER(1), .MODE(MODE_B), .EXT(EXT_B)) probeB (
    .clk(clk), .rstN(rstN), .cke(cke[1]), .csN(csN[1]), .rasN(rasN[1]), .casN(casN[1]),
    .weN(weN[1]), .ba(ba[1]), .addr(addr[1]), .initDone(initDone[1]),
    .checks(chkN[1]), .errors(errN[1]), .finished(fin[1]));

  // DLL reset skipped: lock counted from extended write
  ddr_init_seq #(.STABLE_CYCLES(6), .TRP_CYCLES(3), .TRFC_CYCLES(6), .TMRD_CYCLES(2),
    .LOCK_CYCLES(30), .REFRESH_COUNT(2), .DLL_ORDER(2)) uutSkip (
    .clk(clk), .rstN(rstN), .modeReg(MODE_B), .extModeReg(11'h000),
    .cke(cke[2]), .csN(csN[2]), .rasN(rasN[2]), .casN(casN[2]), .weN(weN[2]),
    .ba(ba[2]), .addr(addr[2]), .initDone(initDone[2]));
  ddr_init_seq_probe #(.S(6), .TRP(3), .TRFC(6), .TMRD(2), .LOCK(30), .NREF(2),
    .ORDER(2), .MODE(MODE_B), .EXT(11'h000)) probeC (
    .clk(clk), .rstN(rstN), .cke(cke[2]), .csN(csN[2]), .rasN(rasN[2]), .casN(casN[2]),
    .weN(weN[2]), .ba(ba[2]), .addr(addr[2]), .initDone(initDone[2]),
    .checks(chkN[2]), .errors(errN[2]), .finished(fin[2]));

  // Both deadlines in the same cycle
  ddr_init_seq #(.STABLE_CYCLES(5), .TRP_CYCLES(3), .TRFC_CYCLES(6), .TMRD_CYCLES(2),
    .LOCK_CYCLES(19), .REFRESH_COUNT(2), .DLL_ORDER(0)) uutTie (
    .clk(clk), .rstN(rstN), .modeReg(MODE_A), .extModeReg(EXT_B),
    .cke(cke[3]), .csN(csN[3]), .rasN(rasN[3]), .casN(casN[3]), .weN(weN[3]),
    .ba(ba[3]), .addr(addr[3]), .initDone(initDone[3]));
  ddr_init_seq_probe #(.S(5), .TRP(3), .TRFC(6), .TMRD(2), .LOCK(19), .NREF(2),
    .ORDER(0), .MODE(MODE_A), .EXT(EXT_B)) probeD (
    .clk(clk), .rstN(rstN), .cke(cke[3]), .csN(csN[3]), .rasN(rasN[3]), .casN(casN[3]),
    .weN(weN[3]), .ba(ba[3]), .addr(addr[3]), .initDone(initDone[3]),
    .checks(chkN[3]), .errors(errN[3]), .finished(fin[3]));

  initial begin
    int total;
    int fails;
    int cyc;
    total = 0; fails = 0; cyc = 0;
    repeat (3) @(posedge clk);
    #2 rstN = 1;
    while (!(fin[0] && fin[1] && fin[2] && fin[3]) && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    #5;
    for (int i = 0; i < 4; i++) begin
      total += chkN[i];
      fails += errN[i];
    end
    if (cyc >= 2000) begin
      total++;
      fails++;
      $display("FAIL R10 watchdog: actual %0d expected below %0d", cyc, 2000);
    end
    $display("CHECKS %0d ERRORS %0d", total, fails);
    $finish;
  end

endmodule